// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block turns single host read and write requests into timed NAND flash bus cycles on an 8-bit or 16-bit I/O bus. Each request carries an address, and two fixed bits of that address decide the kind of cycle. Bit 22 selects a command latch and bit 21 selects an address latch. With neither bit set, the request is a plain data transfer. The block drives an active-low chip enable, an active-low write strobe, an active-low read strobe and active-high command-latch and address-latch lines. The shared data bus is split into an output value, an output enable and an input value, so a pad ring or a tristate buffer can join them.

All timing is counted in clock cycles. For each access the host supplies a setup count, a strobe-pulse count, a total-cycle count and a bus-float count on configuration inputs. The block samples them when it accepts a request. One accepted request produces exactly one command, address or data phase. A one-cycle done pulse follows it, carrying read data or an error flag back to the host. After a read, the float count keeps the block busy so that no new write can drive the bus while the flash may still be releasing it.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, chip enable, write strobe and read strobe are high. The two latch lines, the bus output enable and the done pulse are low, and the request-ready output is high.
- R2: During every clock period of a bus access, the command-latch line equals request address bit 22 and the address-latch line equals request address bit 21. Both lines are low whenever chip enable is high.
- R3: Counting periods k = 0, 1, ... from the first period after acceptance, chip enable is low for exactly the effective cycle count of periods, and high otherwise.
- R4: The strobe of the access (write strobe for writes, read strobe for reads) is low exactly in periods k with setup <= k < setup + pulse. The other strobe stays high.
- R5: On a write, the bus output enable is high and the write data is driven for every chip-enable period. When the bus is wider than 8 bits and either latch bit is set, bits above 7 are driven as zero.
- R6: On a read, the bus output enable stays low. The bus input is sampled at the end of the last strobe-low period, and that value is presented on the read-data output with the done pulse.
- R7: The done output is high for exactly one period: the period right after the last chip-enable period.
- R8: After a write's done pulse, ready returns in the next period. After a read's done pulse, ready stays low for the float count of periods, with chip enable high and the bus undriven, and then returns.
- R9: A request with both address bits 22 and 21 set performs no bus cycle. It produces the done pulse with the error flag high in period k = 0, and ready returns in the next period.
- R10: Configuration inputs are taken in the cycle of acceptance. Changing them during an access does not change that access.
- R11: A pulse count of zero acts as one. A cycle count smaller than setup plus the effective pulse is raised to setup plus the effective pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present; accepted when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host address; bit 22 = command latch, bit 21 = address latch |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | CNT_W | Setup count in clocks |
| cfg_pulse | input | CNT_W | Strobe pulse count in clocks |
| cfg_cycle | input | CNT_W | Total cycle count in clocks |
| cfg_float | input | CNT_W | Bus-float count after reads |
| req_ready | output | 1 | Block idle, can accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (both latch bits set); valid with rsp_done |
| rsp_rdata | output | DATA_W | Read data; valid with rsp_done |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_we_n | output | 1 | Flash write strobe, active low |
| nand_oe_n | output | 1 | Flash read strobe, active low |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_io_out | output | DATA_W | Value driven onto the flash I/O bus |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | DATA_W | Value read from the flash I/O bus |

## Verification
Assertions watch invariants of the pins on every cycle. The two latch lines are never high together. A strobe is only low inside chip enable. The bus is never driven while the read strobe is low. The upper byte is zero on latch cycles, done is a single pulse, ready stays low during chip enable, and a rejected request keeps chip enable high. The exact placement of the strobe edges within the window, the sampling instant of read data, the float length and the isolation from configuration changes in mid-access depend on programmed counts. Only the bench's scenarios can show these, by comparing each period against counts derived from the requirements.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  // Sequencer phases of one host access.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FLOAT = 2'd3
  } seq_state_e;

endpackage

// File: rtl/nand_timing_sel.sv
module nand_timing_sel #(
  parameter int CNT_W = 4,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live_sel,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic [CNT_W-1:0] cfg_cycle,
  input  logic [CNT_W-1:0] cfg_float,
  output logic [CW-1:0]    tm_setup,
  output logic [CW-1:0]    tm_strobe_end,
  output logic [CW-1:0]    tm_cycle_end,
  output logic [CW-1:0]    tm_float
);

  logic [CW-1:0] pulse_eff;
  logic [CW-1:0] setup_live, strobe_live, cycle_live, float_live;
  logic [CW-1:0] setup_q, strobe_q, cycle_q, float_q;

  // Clamp: zero pulse acts as one; cycle never shorter than the strobe end.
  always_comb begin
    pulse_eff   = (cfg_pulse == '0) ? CW'(1) : CW'(cfg_pulse);
    setup_live  = CW'(cfg_setup);
    strobe_live = setup_live + pulse_eff;
    cycle_live  = (CW'(cfg_cycle) < strobe_live) ? strobe_live : CW'(cfg_cycle);
    float_live  = CW'(cfg_float);
  end

  // Track live values while idle; freeze once an access starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q  <= '0;
      strobe_q <= CW'(1);
      cycle_q  <= CW'(1);
      float_q  <= '0;
    end else if (live_sel) begin
      setup_q  <= setup_live;
      strobe_q <= strobe_live;
      cycle_q  <= cycle_live;
      float_q  <= float_live;
    end
  end

  assign tm_setup      = live_sel ? setup_live  : setup_q;
  assign tm_strobe_end = live_sel ? strobe_live : strobe_q;
  assign tm_cycle_end  = live_sel ? cycle_live  : cycle_q;
  assign tm_float      = live_sel ? float_live  : float_q;

  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tm_strobe_end > tm_setup) && (tm_cycle_end >= tm_strobe_end)); // R11

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_strobe_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16,
  localparam int CW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cle,
  input  logic              req_ale,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW-1:0]     tm_cycle_end,
  input  logic [CW-1:0]     tm_float,
  output seq_state_e        state_q,
  output seq_state_e        state_d,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     cnt_d,
  output logic              wr_q,
  output logic              wr_d,
  output logic              cle_d,
  output logic              ale_d,
  output logic              err_d,
  output logic [DATA_W-1:0] wdata_d
);

  logic              cle_q, ale_q, err_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    cle_d   = cle_q;
    ale_d   = ale_q;
    err_d   = err_q;
    wdata_d = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          wr_d    = req_write;
          cle_d   = req_cle;
          ale_d   = req_ale;
          err_d   = req_cle & req_ale;
          wdata_d = req_wdata;
          cnt_d   = '0;
          state_d = (req_cle & req_ale) ? ST_DONE : ST_BUS;
        end
      end
      ST_BUS: begin
        if (cnt_q == tm_cycle_end - CW'(1)) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_DONE: begin
        cnt_d   = '0;
        state_d = (!wr_q && !err_q && tm_float != '0) ? ST_FLOAT : ST_IDLE;
      end
      ST_FLOAT: begin
        if (cnt_q == tm_float - CW'(1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      cle_q   <= cle_d;
      ale_q   <= ale_d;
      err_q   <= err_d;
      wdata_q <= wdata_d;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUS) |-> (cnt_q < tm_cycle_end)); // R3

  AST_FLOAT_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLOAT) |-> (!wr_q && !err_q)); // R8

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_strobe_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16,
  localparam int CW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  seq_state_e        state_d,
  input  logic [CW-1:0]     cnt_q,
  input  logic [CW-1:0]     cnt_d,
  input  logic              wr_q,
  input  logic              wr_d,
  input  logic              cle_d,
  input  logic              ale_d,
  input  logic              err_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [CW-1:0]     tm_setup,
  input  logic [CW-1:0]     tm_strobe_end,
  input  logic [DATA_W-1:0] io_in,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe
);

  logic              bus_d, strobe_d, sample_now;
  logic [DATA_W-1:0] out_val;

  // Latch cycles carry one byte only; clear the upper lanes on wide buses.
  generate
    if (DATA_W > 8) begin : g_wide
      assign out_val = (cle_d | ale_d) ? {{(DATA_W-8){1'b0}}, wdata_d[7:0]} : wdata_d;
    end else begin : g_narrow
      assign out_val = wdata_d;
    end
  endgenerate

  assign bus_d      = (state_d == ST_BUS);
  assign strobe_d   = bus_d && (cnt_d >= tm_setup) && (cnt_d < tm_strobe_end);
  assign sample_now = (state_q == ST_BUS) && !wr_q && (cnt_q == tm_strobe_end - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      io_out    <= '0;
      io_oe     <= 1'b0;
    end else begin
      req_ready <= (state_d == ST_IDLE);
      rsp_done  <= (state_d == ST_DONE);
      rsp_err   <= (state_d == ST_DONE) && err_d;
      ce_n      <= !bus_d;
      we_n      <= !(strobe_d && wr_d);
      oe_n      <= !(strobe_d && !wr_d);
      cle       <= bus_d && cle_d;
      ale       <= bus_d && ale_d;
      io_out    <= (bus_d && wr_d) ? out_val : '0;
      io_oe     <= bus_d && wr_d;
    end
  end

  // Read data capture: last period of the read strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if (sample_now) begin
      rsp_rdata <= io_in;
    end
  end

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !io_oe); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n)); // R4

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int CLE_BIT = 22,
  parameter int ALE_BIT = 21,
  localparam int CW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic [CNT_W-1:0]  cfg_float,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_oe_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DATA_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [DATA_W-1:0] nand_io_in
);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q, wr_d, cle_d, ale_d, err_d;
  logic [DATA_W-1:0] wdata_d;
  logic [CW-1:0]     tm_setup, tm_strobe_end, tm_cycle_end, tm_float;
  logic              addr_unused;

  assign addr_unused = ^req_addr;

  nand_timing_sel #(.CNT_W(CNT_W)) u_timing (
    .clk           (clk),
    .rst           (rst),
    .live_sel      (state_q == ST_IDLE),
    .cfg_setup     (cfg_setup),
    .cfg_pulse     (cfg_pulse),
    .cfg_cycle     (cfg_cycle),
    .cfg_float     (cfg_float),
    .tm_setup      (tm_setup),
    .tm_strobe_end (tm_strobe_end),
    .tm_cycle_end  (tm_cycle_end),
    .tm_float      (tm_float)
  );

  nand_phase_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_cle      (req_addr[CLE_BIT]),
    .req_ale      (req_addr[ALE_BIT]),
    .req_wdata    (req_wdata),
    .tm_cycle_end (tm_cycle_end),
    .tm_float     (tm_float),
    .state_q      (state_q),
    .state_d      (state_d),
    .cnt_q        (cnt_q),
    .cnt_d        (cnt_d),
    .wr_q         (wr_q),
    .wr_d         (wr_d),
    .cle_d        (cle_d),
    .ale_d        (ale_d),
    .err_d        (err_d),
    .wdata_d      (wdata_d)
  );

  nand_pin_drive #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_pins (
    .clk           (clk),
    .rst           (rst),
    .state_q       (state_q),
    .state_d       (state_d),
    .cnt_q         (cnt_q),
    .cnt_d         (cnt_d),
    .wr_q          (wr_q),
    .wr_d          (wr_d),
    .cle_d         (cle_d),
    .ale_d         (ale_d),
    .err_d         (err_d),
    .wdata_d       (wdata_d),
    .tm_setup      (tm_setup),
    .tm_strobe_end (tm_strobe_end),
    .io_in         (nand_io_in),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .ce_n          (nand_ce_n),
    .we_n          (nand_we_n),
    .oe_n          (nand_oe_n),
    .cle           (nand_cle),
    .ale           (nand_ale),
    .io_out        (nand_io_out),
    .io_oe         (nand_io_oe)
  );

  AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale)); // R2

  AST_LATCH_IN_CE: assert property (@(posedge clk) disable iff (rst)
    (nand_cle || nand_ale) |-> !nand_ce_n); // R2

  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_oe_n) |-> !nand_ce_n); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !nand_ce_n |-> !req_ready); // R8

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_err) |-> (nand_ce_n && $past(nand_ce_n))); // R9

  generate
    if (DATA_W > 8) begin : g_upper_chk
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (nand_io_oe && (nand_cle || nand_ale)) |-> (nand_io_out[DATA_W-1:8] == '0)); // R5
    end
  endgenerate

endmodule

// File: tb/nand_strobe_gen_tb_top.sv
module nand_strobe_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int CNW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic [CNW-1:0] cfg_setup = 4'd1, cfg_pulse = 4'd3, cfg_cycle = 4'd5, cfg_float = 4'd2;
  logic           req_ready, rsp_done, rsp_err;
  logic [DW-1:0]  rsp_rdata, nand_io_out, nand_io_in;
  logic           nand_ce_n, nand_we_n, nand_oe_n, nand_cle, nand_ale, nand_io_oe;
  logic [DW-1:0]  rd_val = '0;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic          err;
    logic          rd;
    logic [DW-1:0] data;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Flash model: returns data only while the read strobe is low.
  assign nand_io_in = !nand_oe_n ? rd_val : 16'hDEAD;

  nand_strobe_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .cfg_float(cfg_float),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: pops the scoreboard at every done pulse.
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R7 done without request", 32'd1, 32'd0);
      end else begin
        mon_e = sb_q.pop_front();
        chk(rsp_err == mon_e.err, "R9 error flag", 32'(rsp_err), 32'(mon_e.err));
        if (mon_e.rd && !mon_e.err)
          chk(rsp_rdata == mon_e.data, "R6 read data", 32'(rsp_rdata), 32'(mon_e.data));
      end
    end
  end

  // Driver: one host access, with a per-period check of the pins.
  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rv, input int su, input int pu, input int cy,
                        input int fl, input bit scramble, input string note);
    bit bad, inbus, stb;
    int pe, se, ce, last;
    logic [DW-1:0] expd;
    logic [7:0] act_v, exp_v;
    bit ok_ce, ok_stb, ok_lat, ok_dat, ok_done;
    logic [31:0] a_ce, e_ce, a_stb, e_stb, a_lat, e_lat, a_dat, e_dat, a_dn, e_dn;
    bad  = addr[22] && addr[21];
    pe   = (pu == 0) ? 1 : pu;
    se   = su + pe;
    ce   = (cy < se) ? se : cy;
    last = bad ? 0 : ce;
    expd = (addr[22] || addr[21]) ? {8'h00, wd[7:0]} : wd;
    ok_ce = 1; ok_stb = 1; ok_lat = 1; ok_dat = 1; ok_done = 1;
    a_ce = 0; e_ce = 0; a_stb = 0; e_stb = 0; a_lat = 0; e_lat = 0;
    a_dat = 0; e_dat = 0; a_dn = 0; e_dn = 0;
    sb_q.push_back('{err: bad, rd: !wr, data: rv});
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; rd_val = rv;
    cfg_setup = CNW'(su); cfg_pulse = CNW'(pu); cfg_cycle = CNW'(cy); cfg_float = CNW'(fl);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_setup = 4'd0; cfg_pulse = 4'd15; cfg_cycle = 4'd15; cfg_float = 4'd0;
    end
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      inbus = (k < last) && !bad;
      stb   = inbus && (k >= su) && (k < se);
      act_v = {1'b0, nand_ce_n, nand_we_n, nand_oe_n, nand_cle, nand_ale, nand_io_oe, rsp_done};
      exp_v = {1'b0, !inbus, !(stb && wr), !(stb && !wr), inbus && addr[22], inbus && addr[21],
               inbus && wr, k == last};
      if (ok_ce && act_v[6] !== exp_v[6]) begin ok_ce = 0; a_ce = 32'(k); e_ce = 32'(act_v); end
      if (ok_stb && act_v[5:4] !== exp_v[5:4]) begin ok_stb = 0; a_stb = 32'(act_v); e_stb = 32'(exp_v); end
      if (ok_lat && act_v[3:2] !== exp_v[3:2]) begin ok_lat = 0; a_lat = 32'(act_v); e_lat = 32'(exp_v); end
      if (ok_dat && (act_v[1] !== exp_v[1] || (inbus && wr && nand_io_out !== expd))) begin
        ok_dat = 0; a_dat = 32'(nand_io_out); e_dat = 32'(expd);
      end
      if (ok_done && act_v[0] !== exp_v[0]) begin ok_done = 0; a_dn = 32'(k); e_dn = 32'(last); end
    end
    chk(ok_ce,  {"R3 chip enable window ", note}, a_ce, e_ce);
    chk(ok_stb, {"R4 strobe placement ", note}, a_stb, e_stb);
    chk(ok_lat, {"R2 latch lines ", note}, a_lat, e_lat);
    chk(ok_dat, {wr ? "R5 write drive " : "R6 read bus released ", note}, a_dat, e_dat);
    chk(ok_done, {"R7 done period ", note}, a_dn, e_dn);
    if (!wr && !bad) begin
      for (int j = 0; j < fl; j++) begin
        @(negedge clk);
        chk(!req_ready && nand_ce_n && !nand_io_oe, "R8 float hold",
            32'({req_ready, nand_ce_n, nand_io_oe}), 32'b010);
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, {"R8 ready return ", note}, 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    // R1: reset values, during reset and right after release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({nand_ce_n, nand_we_n, nand_oe_n, nand_cle, nand_ale, nand_io_oe, rsp_done, req_ready} == 8'b1110_0001,
        "R1 reset pins", 32'({nand_ce_n, nand_we_n, nand_oe_n, nand_cle, nand_ale, nand_io_oe, rsp_done, req_ready}),
        32'b1110_0001);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && nand_ce_n && !rsp_done, "R1 after release",
        32'({req_ready, nand_ce_n, rsp_done}), 32'b110);

    // Default timing, data write on the full bus (R4, R5)
    access(1'b1, 24'h000100, 16'hBEEF, 16'h0000, 1, 3, 5, 2, 1'b0, "data write");
    // Command latch: CLE high, upper byte zero (R2, R5)
    access(1'b1, 24'h400000, 16'h1290, 16'h0000, 1, 3, 5, 2, 1'b0, "command");
    // Address latch: ALE high, upper byte zero (R2, R5)
    access(1'b1, 24'h200000, 16'h7733, 16'h0000, 1, 3, 5, 2, 1'b0, "address");
    // Default read with float of 2 (R6, R8)
    access(1'b0, 24'h000000, 16'h0000, 16'h5AC3, 1, 3, 5, 2, 1'b0, "default read");
    // Minimal read: no setup, one-cycle pulse, no float (R6, R8)
    access(1'b0, 24'h000004, 16'h0000, 16'h0F1E, 0, 1, 2, 0, 1'b0, "short read");
    // Long read with float of 3
    access(1'b0, 24'h000008, 16'h0000, 16'hC0DE, 2, 4, 9, 3, 1'b0, "long read");
    // R9: both latch bits set on a write and on a read
    access(1'b1, 24'h600000, 16'hAAAA, 16'h0000, 1, 3, 5, 2, 1'b0, "R9 reject write");
    access(1'b0, 24'h600010, 16'h0000, 16'h1111, 1, 3, 5, 2, 1'b0, "R9 reject read");
    // R11: zero pulse acts as one, short cycle stretched to setup+pulse
    access(1'b1, 24'h000020, 16'h4321, 16'h0000, 2, 0, 1, 0, 1'b0, "R11 clamp write");
    access(1'b0, 24'h000024, 16'h0000, 16'h9876, 3, 2, 0, 1, 1'b0, "R11 clamp read");
    // R10: configuration changed mid-access must not alter it
    access(1'b1, 24'h000030, 16'h2468, 16'h0000, 1, 2, 6, 0, 1'b1, "R10 cfg write");
    access(1'b0, 24'h000034, 16'h0000, 16'h1357, 2, 2, 7, 2, 1'b1, "R10 cfg read");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all responses seen", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

endmodule